// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block handles the register transfer a processor performs when it enters an event handler. A one-cycle `take_event` strobe samples a pending exception code and a pending hardware interrupt request, which carries its own code and priority level. The block then decides whether to take the exception, take the interrupt, turn the event into a reset, or do nothing.

When an event is taken, the block saves the status register, the return address and R15. It sets the handler-mode bits in the status register, records the event code, and produces the handler address.

The register file and the pipeline stay outside the block. It only computes and holds the values that a core loads at entry. The code sets for reset, TLB miss, trap and block exemption are parameters. Status register field positions are fixed, because the handler decodes them: block bit 28, register-bank bit 29, privileged-mode bit 30, interrupt mask bits 7:4.

Top module: `exc_entry_seq`

## Requirements
- R1: When `take_event` is high and both `exc_valid` and `irq_req` are high, the exception is taken and the interrupt is dropped. `kind` never reports an interrupt in that case.
- R2: When `sr_in[28]` is set, a pending exception with any code other than 0x1E0 becomes a reset: `kind`=3 and `expevt`=0x000. Code 0x1E0 is taken as an ordinary exception.
- R3: When `sr_in[28]` is set and only an interrupt is pending, nothing is taken. `taken` stays 0 and every saved register keeps its value.
- R4: An interrupt with no exception pending is taken (`kind`=2) only if `irq_level` is strictly greater than `sr_in[7:4]`. Otherwise nothing is taken.
- R5: On any taken event, the following are loaded: `ssr`=`sr_in`, `sgr`=`r15_in`, and `sr_out`=`sr_in` with bits 30, 29 and 28 set. For events other than reset, all other bits of `sr_out` keep their input values.
- R6: When `dslot_in` is high at entry, `spc` is `pc_in`-2 and `dslot_clear` pulses for one cycle. Otherwise `spc`=`pc_in` (subject to R10).
- R7: A reset (`kind`=3) loads `pc_out`=0xA0000000 and forces `sr_out[7:4]`=0xF. An exception whose code is itself 0x000 or 0x020 also takes the reset path, and its code goes to `expevt`.
- R8: Exceptions with code 0x040 or 0x060 (TLB miss) set `pc_out`=`vbr_in`+0x400. Any other non-reset exception sets `pc_out`=`vbr_in`+0x100. In both cases `expevt` gets the code.
- R9: A taken interrupt sets `pc_out`=`vbr_in`+0x600 and `intevt`=`irq_code`, and leaves `expevt` unchanged.
- R10: The trap exception (code 0x160) sets `spc` to the return address plus 2.
- R11: All results appear on the first clock edge after the `take_event` cycle. `taken` is a one-cycle pulse. `kind` encodes 0 none, 1 exception, 2 interrupt, 3 reset. Without `take_event`, or with no event taken, all saved registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_event | input | 1 | One-cycle strobe that samples pending events |
| exc_valid | input | 1 | An exception is pending |
| exc_code | input | 12 | Pending exception code |
| irq_req | input | 1 | Hardware interrupt request |
| irq_code | input | 12 | Interrupt event code |
| irq_level | input | 4 | Interrupt priority level |
| sr_in | input | 32 | Current status register |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current R15 |
| vbr_in | input | 32 | Vector base register |
| dslot_in | input | 1 | Event hits inside a delay slot |
| taken | output | 1 | Pulse: an event was taken |
| kind | output | 2 | Class of the last decision |
| sr_out | output | 32 | Status register for the handler |
| pc_out | output | 32 | Handler address |
| ssr | output | 32 | Saved status register |
| spc | output | 32 | Saved return address |
| sgr | output | 32 | Saved R15 |
| expevt | output | 12 | Exception event code register |
| intevt | output | 12 | Interrupt event code register |
| dslot_clear | output | 1 | Pulse: delay-slot flags must be cleared |

## Verification
The decision and every result register sit behind a single register stage. Each effect of a strobe applied in cycle N is therefore visible after the clock edge that ends cycle N, and `taken`, `kind` and `dslot_clear` fall back after one more edge.

The driver stamps each expected item with the cycle count at which it is due. The monitor compares it on the falling edge of exactly that cycle, never earlier and never later. Cases that take no event carry the previous expected register values, so holding is checked on the same cycle as any other result.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int DW = 32;
  localparam int CW = 12;
  localparam int LW = 4;
  localparam int SR_BL = 28;
  localparam int SR_RB = 29;
  localparam int SR_MD = 30;
  localparam int MASK_LO = 4;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_EXC  = 2'd1,
    EV_IRQ  = 2'd2,
    EV_RST  = 2'd3
  } ev_kind_t;

  // Return address after delay-slot rewind and trap advance.
  function automatic logic [DW-1:0] return_addr(logic [DW-1:0] pc, logic in_slot,
                                                logic is_trap);
    logic [DW-1:0] a;
    a = in_slot ? pc - DW'(2) : pc;
    if (is_trap) a = a + DW'(2);
    return a;
  endfunction

  // Handler address per event class.
  function automatic logic [DW-1:0] handler_addr(ev_kind_t k, logic [DW-1:0] vbr,
                                                 logic tlb_miss, logic [DW-1:0] rst_pc);
    logic [DW-1:0] a;
    case (k)
      EV_RST:  a = rst_pc;
      EV_IRQ:  a = vbr + DW'(32'h600);
      default: a = tlb_miss ? vbr + DW'(32'h400) : vbr + DW'(32'h100);
    endcase
    return a;
  endfunction
endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import exc_entry_pkg::*;
#(
  parameter logic [CW-1:0] EXEMPT_CODE = 12'h1E0,
  parameter logic [CW-1:0] RST_CODE_A  = 12'h000,
  parameter logic [CW-1:0] RST_CODE_B  = 12'h020
) (
  input  logic          take,
  input  logic          exc_valid,
  input  logic [CW-1:0] exc_code,
  input  logic          irq_req,
  input  logic [LW-1:0] irq_level,
  input  logic [DW-1:0] sr,
  output ev_kind_t      kind,
  output logic [CW-1:0] code_eff
);
  logic          blocked;
  logic          exc_to_rst;
  logic          is_rst_code;
  logic          irq_above;
  logic [LW-1:0] imask;

  assign blocked     = sr[SR_BL];
  assign imask       = sr[MASK_LO +: LW];
  assign is_rst_code = (exc_code == RST_CODE_A) || (exc_code == RST_CODE_B);
  assign exc_to_rst  = blocked && (exc_code != EXEMPT_CODE);
  assign irq_above   = irq_level > imask;

  always_comb begin
    kind     = EV_NONE;
    code_eff = exc_code;
    if (take) begin
      if (exc_valid) begin
        if (exc_to_rst) begin
          kind     = EV_RST;
          code_eff = RST_CODE_A;
        end else if (is_rst_code) begin
          kind = EV_RST;
        end else begin
          kind = EV_EXC;
        end
      end else if (irq_req && !blocked && irq_above) begin
        kind = EV_IRQ;
      end
    end
  end
endmodule

// File: rtl/entry_calc.sv
module entry_calc
  import exc_entry_pkg::*;
#(
  parameter logic [CW-1:0] TLB_CODE_A = 12'h040,
  parameter logic [CW-1:0] TLB_CODE_B = 12'h060,
  parameter logic [CW-1:0] TRAP_CODE  = 12'h160,
  parameter logic [DW-1:0] RST_PC     = 32'hA000_0000
) (
  input  ev_kind_t      kind,
  input  logic [CW-1:0] code,
  input  logic [DW-1:0] sr,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] vbr,
  input  logic          in_slot,
  output logic [DW-1:0] new_sr,
  output logic [DW-1:0] new_pc,
  output logic [DW-1:0] ret_pc
);
  logic tlb_miss;
  logic is_trap;

  assign tlb_miss = (code == TLB_CODE_A) || (code == TLB_CODE_B);
  assign is_trap  = (kind == EV_EXC) && (code == TRAP_CODE);

  always_comb begin
    new_sr = sr;
    new_sr[SR_BL] = 1'b1;
    new_sr[SR_RB] = 1'b1;
    new_sr[SR_MD] = 1'b1;
    if (kind == EV_RST) new_sr[MASK_LO +: LW] = '1;
  end

  assign new_pc = handler_addr(kind, vbr, tlb_miss, RST_PC);
  assign ret_pc = return_addr(pc, in_slot, is_trap);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter logic [CW-1:0] EXEMPT_CODE = 12'h1E0,
  parameter logic [CW-1:0] RST_CODE_A  = 12'h000,
  parameter logic [CW-1:0] RST_CODE_B  = 12'h020,
  parameter logic [CW-1:0] TLB_CODE_A  = 12'h040,
  parameter logic [CW-1:0] TLB_CODE_B  = 12'h060,
  parameter logic [CW-1:0] TRAP_CODE   = 12'h160,
  parameter logic [DW-1:0] RST_PC      = 32'hA000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_event,
  input  logic          exc_valid,
  input  logic [11:0]   exc_code,
  input  logic          irq_req,
  input  logic [11:0]   irq_code,
  input  logic [3:0]    irq_level,
  input  logic [31:0]   sr_in,
  input  logic [31:0]   pc_in,
  input  logic [31:0]   r15_in,
  input  logic [31:0]   vbr_in,
  input  logic          dslot_in,
  output logic          taken,
  output logic [1:0]    kind,
  output logic [31:0]   sr_out,
  output logic [31:0]   pc_out,
  output logic [31:0]   ssr,
  output logic [31:0]   spc,
  output logic [31:0]   sgr,
  output logic [11:0]   expevt,
  output logic [11:0]   intevt,
  output logic          dslot_clear
);
  ev_kind_t      dec_kind;
  logic [CW-1:0] dec_code;
  logic [DW-1:0] nxt_sr, nxt_pc, nxt_ret;
  logic          ev_go;

  evt_arbiter #(
    .EXEMPT_CODE(EXEMPT_CODE), .RST_CODE_A(RST_CODE_A), .RST_CODE_B(RST_CODE_B)
  ) u_arb (
    .take(take_event), .exc_valid(exc_valid), .exc_code(exc_code),
    .irq_req(irq_req), .irq_level(irq_level), .sr(sr_in),
    .kind(dec_kind), .code_eff(dec_code)
  );

  entry_calc #(
    .TLB_CODE_A(TLB_CODE_A), .TLB_CODE_B(TLB_CODE_B),
    .TRAP_CODE(TRAP_CODE), .RST_PC(RST_PC)
  ) u_calc (
    .kind(dec_kind), .code(dec_code), .sr(sr_in), .pc(pc_in), .vbr(vbr_in),
    .in_slot(dslot_in), .new_sr(nxt_sr), .new_pc(nxt_pc), .ret_pc(nxt_ret)
  );

  assign ev_go = (dec_kind != EV_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken <= 1'b0; kind <= EV_NONE; dslot_clear <= 1'b0;
      sr_out <= '0; pc_out <= '0; ssr <= '0; spc <= '0; sgr <= '0;
      expevt <= '0; intevt <= '0;
    end else begin
      taken       <= ev_go;
      kind        <= dec_kind;
      dslot_clear <= ev_go && dslot_in;
      if (ev_go) begin
        sr_out <= nxt_sr;
        pc_out <= nxt_pc;
        ssr    <= sr_in;
        spc    <= nxt_ret;
        sgr    <= r15_in;
        if (dec_kind == EV_IRQ) intevt <= irq_code;
        else                    expevt <= dec_code;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        take_event,
  input logic        exc_valid,
  input logic        irq_req,
  input logic [3:0]  irq_level,
  input logic [31:0] sr_in,
  input logic        taken,
  input logic [1:0]  kind,
  input logic [31:0] sr_out,
  input logic [31:0] pc_out,
  input logic [31:0] spc
);
  a_r1_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    take_event && exc_valid && irq_req |=> taken && kind != 2'd2);
  a_r3_block_irq: assert property (@(posedge clk) disable iff (!rst_n)
    take_event && !exc_valid && sr_in[28] |=> !taken);
  a_r4_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
    take_event && !exc_valid && irq_req && !sr_in[28] && irq_level <= sr_in[7:4] |=> !taken);
  a_r4_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    take_event && !exc_valid && irq_req && !sr_in[28] && irq_level > sr_in[7:4]
    |=> taken && kind == 2'd2);
  a_r5_mode_bits: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> sr_out[30:28] == 3'b111);
  a_r7_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
    taken && kind == 2'd3 |-> pc_out == 32'hA000_0000 && sr_out[7:4] == 4'hF);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take_event |=> !taken && $stable(spc) && $stable(pc_out));
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .take_event(take_event), .exc_valid(exc_valid),
  .irq_req(irq_req), .irq_level(irq_level), .sr_in(sr_in), .taken(taken),
  .kind(kind), .sr_out(sr_out), .pc_out(pc_out), .spc(spc)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic take_event = 0, exc_valid = 0, irq_req = 0, dslot_in = 0;
  logic [11:0] exc_code = 0, irq_code = 0;
  logic [3:0]  irq_level = 0;
  logic [31:0] sr_in = 0, pc_in = 0, r15_in = 0, vbr_in = 0;
  logic taken, dslot_clear;
  logic [1:0] kind;
  logic [31:0] sr_out, pc_out, ssr, spc, sgr;
  logic [11:0] expevt, intevt;

  exc_entry_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int due; string tag;
    logic tk; logic [1:0] kd; logic dc;
    logic [31:0] sr, pc, ssr, spc, sgr;
    logic [11:0] ev, iv;
  } exp_t;

  exp_t q[$];
  exp_t m;
  int cyc = 0, checks = 0, fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares each item on the falling edge of its due cycle.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({taken, kind, dslot_clear, sr_out, pc_out, ssr, spc, sgr, expevt, intevt} !==
          {e.tk, e.kd, e.dc, e.sr, e.pc, e.ssr, e.spc, e.sgr, e.ev, e.iv}) begin
        fails++;
        $display("FAIL %s: got tk=%0b kd=%0d dc=%0b sr=%h pc=%h ssr=%h spc=%h sgr=%h ev=%h iv=%h exp tk=%0b kd=%0d dc=%0b sr=%h pc=%h ssr=%h spc=%h sgr=%h ev=%h iv=%h",
          e.tag, taken, kind, dslot_clear, sr_out, pc_out, ssr, spc, sgr, expevt, intevt,
          e.tk, e.kd, e.dc, e.sr, e.pc, e.ssr, e.spc, e.sgr, e.ev, e.iv);
      end
    end
  end

  // Driver: applies one strobe, predicts results from the requirements.
  task automatic send(input logic te, input logic ex, input logic [11:0] ec,
                      input logic ir, input logic [11:0] ic, input logic [3:0] il,
                      input logic [31:0] sr, input logic [31:0] pc,
                      input logic [31:0] vbr, input logic ds, input string tag);
    logic [1:0] k;
    logic [11:0] code;
    @(negedge clk);
    take_event = te; exc_valid = ex; exc_code = ec; irq_req = ir; irq_code = ic;
    irq_level = il; sr_in = sr; pc_in = pc; vbr_in = vbr; dslot_in = ds;
    r15_in = pc ^ 32'h5A5A_0000;
    k = 0; code = ec;
    if (te && ex) begin
      if (sr[28] && ec != 12'h1E0) begin k = 3; code = 12'h000; end
      else if (ec == 12'h000 || ec == 12'h020) k = 3;
      else k = 1;
    end else if (te && ir && !sr[28] && il > sr[7:4]) k = 2;
    m.due = cyc + 1; m.tag = tag; m.tk = (k != 0); m.kd = k; m.dc = (k != 0) && ds;
    if (k != 0) begin
      m.ssr = sr; m.sgr = r15_in;
      m.spc = pc - (ds ? 32'd2 : 32'd0) + ((k == 1 && ec == 12'h160) ? 32'd2 : 32'd0);
      m.sr = sr | 32'h7000_0000 | ((k == 3) ? 32'h0000_00F0 : 32'h0);
      if (k == 3) m.pc = 32'hA000_0000;
      else if (k == 2) m.pc = vbr + 32'h600;
      else if (ec == 12'h040 || ec == 12'h060) m.pc = vbr + 32'h400;
      else m.pc = vbr + 32'h100;
      if (k == 2) m.iv = ic; else m.ev = code;
    end
    q.push_back(m);
    @(negedge clk);
    take_event = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m = '{due:0, tag:"", tk:0, kd:0, dc:0, sr:0, pc:0, ssr:0, spc:0, sgr:0, ev:0, iv:0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({taken, kind, dslot_clear, sr_out, pc_out, spc, expevt} !== '0) begin
      fails++;
      $display("FAIL R11 reset state: got %b exp 0", {taken, kind, dslot_clear, pc_out, spc});
    end
    rst_n = 1;
    send(1, 1, 12'h0E0, 0, 0, 0, 32'h4000_0030, 32'h0000_1000, 32'h8000_0000, 0, "R5 R8 general exception");
    send(1, 1, 12'h040, 0, 0, 0, 32'h0000_0000, 32'h0000_2000, 32'h8C00_0000, 0, "R8 tlb miss read");
    send(1, 1, 12'h060, 0, 0, 0, 32'h0000_0000, 32'h0000_2100, 32'h8C00_0000, 0, "R8 tlb miss write");
    send(1, 1, 12'h160, 0, 0, 0, 32'h4000_0000, 32'h0000_3000, 32'h8000_0000, 0, "R10 trap");
    send(1, 1, 12'h180, 0, 0, 0, 32'h4000_0000, 32'h0000_4002, 32'h8000_0000, 1, "R6 delay slot");
    send(1, 0, 12'h0,   1, 12'h320, 4'd5, 32'h4000_0030, 32'h0000_5000, 32'h8000_0000, 0, "R9 interrupt taken");
    send(1, 0, 12'h0,   1, 12'h340, 4'd3, 32'h4000_0030, 32'h0000_5100, 32'h8000_0000, 0, "R4 interrupt at mask ignored");
    send(1, 0, 12'h0,   1, 12'h360, 4'hF, 32'h0000_00E0, 32'h0000_5200, 32'h9000_0000, 0, "R4 level F over mask E");
    send(1, 1, 12'h0A0, 1, 12'h380, 4'hF, 32'h0000_0000, 32'h0000_6000, 32'h8000_0000, 0, "R1 exception beats interrupt");
    send(1, 1, 12'h0E0, 0, 0, 0, 32'h5000_0000, 32'h0000_7000, 32'h8000_0000, 0, "R2 blocked exception to reset");
    send(1, 1, 12'h1E0, 0, 0, 0, 32'h5000_0000, 32'h0000_7100, 32'h8000_0000, 0, "R2 exempt code under block");
    send(1, 0, 12'h0,   1, 12'h3A0, 4'hF, 32'h1000_0000, 32'h0000_7200, 32'h8000_0000, 0, "R3 interrupt blocked");
    send(0, 1, 12'h0E0, 1, 12'h3C0, 4'hF, 32'h0000_0000, 32'h0000_7300, 32'h8000_0000, 1, "R11 no strobe holds");
    send(1, 1, 12'h020, 0, 0, 0, 32'h0000_0000, 32'h0000_7400, 32'h8000_0000, 0, "R7 reset code direct");
    send(1, 0, 12'h0,   0, 0, 0, 32'h0000_0000, 32'h0000_7500, 32'h8000_0000, 0, "R11 strobe with nothing pending");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule